// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives a system reset from three sources: power-on, a drop in supply voltage, and expiry of a watchdog. A supply-good flag, already sampled into the clock domain, tells it when the supply is healthy. A 1 ms enable pulse (`tick_i`) sets the time base, and every interval is a whole number of these ticks. After power-up, the reset output stays asserted until the supply-good flag has been true without a break for the hold time. Any drop of the flag asserts reset again at once, and the hold starts over from zero.

The watchdog is restarted only by a START condition on the two-wire bus. A START is a falling edge on SDA while SCL is high. Both lines pass through two-flop synchronizers before edge detection. A 2-bit select chooses the watchdog period or turns the watchdog off. The select is captured only when the counter reloads, which happens on a restart or at the end of a reset hold. If the count runs out, reset is held for the same hold time, and then the watchdog reloads and runs again. A START that arrives while any reset hold is running is ignored. While the supply is low, `bus_abort_o` tells the serial engine to drop the current transfer and refuse new commands. The signal concerns bus transfers only and has no effect on a nonvolatile write that is already in progress.

The controller has four states. `ST_PWR_WAIT` means the supply is low. `ST_PWR_HOLD` means the supply is good and the hold is counting. `ST_RUN` means reset is released. `ST_WD_HOLD` means the watchdog has expired and the hold is counting. The transitions are:
- WAIT→PWR_HOLD when the supply becomes good.
- PWR_HOLD→RUN and WD_HOLD→RUN when the hold completes.
- RUN→WD_HOLD on watchdog expiry.
- Any state→WAIT when the supply drops.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1. With the supply flag low, `bus_abort_o` is also 1.
- R2: Once `pwr_ok_i` is high, `sys_rst_o` stays 1 through HOLD_TICKS−1 ticks. It falls on the clock edge that takes tick number HOLD_TICKS.
- R3: When `pwr_ok_i` goes low, `sys_rst_o` is 1 in the same cycle. A hold that was interrupted restarts from zero when the supply returns.
- R4: `bus_abort_o` is 1 while the supply flag is low and in `ST_PWR_WAIT`. It is 0 in every other state, including the watchdog hold.
- R5: The period select maps 00 to PERIOD_SLOW ticks, 01 to PERIOD_MID ticks and 10 to PERIOD_FAST ticks. Without a restart, reset rises on the edge that takes the last tick of the selected period.
- R6: Select 11 turns the watchdog off. The counter stays idle and never asserts reset.
- R7: A falling SDA while SCL is high reloads the full selected period. A falling SDA while SCL is low does not reload it.
- R8: A START during a reset hold has no effect, and the hold still lasts HOLD_TICKS ticks.
- R9: After an expiry, reset is held for HOLD_TICKS ticks. The watchdog then reloads and counts again.
- R10: A change of the select takes effect only at the next reload, which is a restart or the end of a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Sampled supply-good flag |
| tick_i | input | 1 | 1 ms timebase enable pulse |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| wd_sel_i | input | 2 | Watchdog period select, 11 = off |
| sys_rst_o | output | 1 | System reset, active high |
| bus_abort_o | output | 1 | Abort/refuse serial transfers on low supply |

## Verification
The assertions check on every cycle that a low supply forces the wait state on the next edge. They also check that reset is released only on a tick that ends a hold, that a watchdog hold is left only on a tick or a supply loss, that the counters stay in range, and that an idle watchdog never expires. Exact period lengths for each select value must be shown by the bench scenarios. The same holds for deferred adoption of a new select, for the rejection of an SDA fall while SCL is low, and for a restart inside a hold being ignored.

// File: rtl/supv_pkg.sv
package supv_pkg;
    typedef enum logic [1:0] {
        ST_PWR_WAIT,
        ST_PWR_HOLD,
        ST_RUN,
        ST_WD_HOLD
    } supv_state_e;

    localparam logic [1:0] WD_SEL_SLOW = 2'b00;
    localparam logic [1:0] WD_SEL_MID  = 2'b01;
    localparam logic [1:0] WD_SEL_FAST = 2'b10;
    localparam logic [1:0] WD_SEL_OFF  = 2'b11;
endpackage

// File: rtl/supv_start_det.sv
module supv_start_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_q, sda_q;
    logic scl_now, sda_now;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_now;
            sda_q    <= sda_now;
        end
    end

    assign scl_now = scl_sync[SYNC_STAGES-1];
    assign sda_now = sda_sync[SYNC_STAGES-1];
    assign start_o = scl_now && scl_q && sda_q && !sda_now;

    // R7: a START is a single-cycle event
    p_start_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);
endmodule

// File: rtl/supv_hold_tmr.sv
module supv_hold_tmr #(
    parameter int HOLD_TICKS = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == HOLD_LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = !clear_i && tick_i && (cnt_q == HOLD_LAST);

    // R2: the hold count never passes its last value
    p_hold_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= HOLD_LAST);
endmodule

// File: rtl/supv_wd_ctr.sv
module supv_wd_ctr
    import supv_pkg::*;
#(
    parameter int PERIOD_SLOW = 1750,
    parameter int PERIOD_MID  = 750,
    parameter int PERIOD_FAST = 250
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       load_i,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       expire_o
);
    localparam int PMAX = (PERIOD_SLOW > PERIOD_MID)
                        ? ((PERIOD_SLOW > PERIOD_FAST) ? PERIOD_SLOW : PERIOD_FAST)
                        : ((PERIOD_MID  > PERIOD_FAST) ? PERIOD_MID  : PERIOD_FAST);
    localparam int CW = $clog2(PMAX + 1);
    localparam logic [CW-1:0] LD_SLOW = CW'(PERIOD_SLOW);
    localparam logic [CW-1:0] LD_MID  = CW'(PERIOD_MID);
    localparam logic [CW-1:0] LD_FAST = CW'(PERIOD_FAST);
    localparam logic [CW-1:0] CNT_MAX = CW'(PMAX);

    logic [CW-1:0] cnt_q, load_val;
    logic [1:0]    sel_q;

    always_comb begin
        unique case (sel_i)
            WD_SEL_SLOW: load_val = LD_SLOW;
            WD_SEL_MID:  load_val = LD_MID;
            WD_SEL_FAST: load_val = LD_FAST;
            default:     load_val = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            sel_q <= WD_SEL_OFF;
        end else if (load_i) begin
            cnt_q <= load_val;
            sel_q <= sel_i;
        end else if (run_i && tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = run_i && tick_i && (cnt_q == CW'(1));

    // R6: an idle watchdog never expires
    p_off_no_expire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_q == WD_SEL_OFF) |-> !expire_o);
    // R5: count never exceeds the longest period
    p_cnt_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_MAX);
    // R5: the count moves only on a tick or a reload
    p_cnt_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
    import supv_pkg::*;
#(
    parameter int HOLD_TICKS  = 250,
    parameter int PERIOD_SLOW = 1750,
    parameter int PERIOD_MID  = 750,
    parameter int PERIOD_FAST = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pwr_ok_i,
    input  logic       tick_i,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] wd_sel_i,
    output logic       sys_rst_o,
    output logic       bus_abort_o
);
    supv_state_e state_q, state_d;
    logic start_evt, hold_done, wd_expire;
    logic hold_clear, wd_load, wd_run;

    supv_start_det #(.SYNC_STAGES(SYNC_STAGES)) u_start (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_evt)
    );

    assign hold_clear = !pwr_ok_i ||
                        !(state_q == ST_PWR_HOLD || state_q == ST_WD_HOLD);

    supv_hold_tmr #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (hold_clear),
        .tick_i  (tick_i),
        .done_o  (hold_done)
    );

    // Outside RUN the counter is kept loaded; in RUN only a START reloads it.
    assign wd_run  = (state_q == ST_RUN);
    assign wd_load = !wd_run || start_evt;

    supv_wd_ctr #(
        .PERIOD_SLOW (PERIOD_SLOW),
        .PERIOD_MID  (PERIOD_MID),
        .PERIOD_FAST (PERIOD_FAST)
    ) u_wd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (wd_load),
        .run_i    (wd_run),
        .tick_i   (tick_i),
        .sel_i    (wd_sel_i),
        .expire_o (wd_expire)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_PWR_WAIT;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWR_WAIT: if (pwr_ok_i) state_d = ST_PWR_HOLD;
            ST_PWR_HOLD: begin
                if (!pwr_ok_i)      state_d = ST_PWR_WAIT;
                else if (hold_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!pwr_ok_i)      state_d = ST_PWR_WAIT;
                else if (wd_expire) state_d = ST_WD_HOLD;
            end
            ST_WD_HOLD: begin
                if (!pwr_ok_i)      state_d = ST_PWR_WAIT;
                else if (hold_done) state_d = ST_RUN;
            end
            default: state_d = ST_PWR_WAIT;
        endcase
    end

    always_comb begin
        sys_rst_o   = (state_q != ST_RUN) || !pwr_ok_i;
        bus_abort_o = (state_q == ST_PWR_WAIT) || !pwr_ok_i;
    end

    // R3: a low supply sends the controller to the wait state
    p_lowsup_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_ok_i |=> state_q == ST_PWR_WAIT);
    // R2: reset is released only on a tick that ends a hold
    p_release_on_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> ($past(tick_i) &&
            ($past(state_q) == ST_PWR_HOLD || $past(state_q) == ST_WD_HOLD)));
    // R8: without a tick the watchdog hold cannot end, whatever the bus does
    p_hold_kick_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WD_HOLD && pwr_ok_i && !tick_i) |=> state_q == ST_WD_HOLD);
    // R4: no bus abort during a watchdog hold with good supply
    p_no_abort_wd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_WD_HOLD && pwr_ok_i) |-> !bus_abort_o);
endmodule

// File: tb/tb_supv_reset_ctrl.sv
module tb_supv_reset_ctrl;
    localparam int HOLD = 8;
    localparam int PS   = 40;
    localparam int PM   = 20;
    localparam int PF   = 12;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic pwr_ok = 1'b0;
    logic tick = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic [1:0] sel = 2'b10;
    logic sys_rst, bus_abort;
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    supv_reset_ctrl #(
        .HOLD_TICKS(HOLD), .PERIOD_SLOW(PS), .PERIOD_MID(PM), .PERIOD_FAST(PF)
    ) dut (
        .clk_i(clk), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok), .tick_i(tick),
        .scl_i(scl), .sda_i(sda), .wd_sel_i(sel),
        .sys_rst_o(sys_rst), .bus_abort_o(bus_abort)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic kick();
        @(negedge clk) sda = 1'b0;
        repeat (4) @(negedge clk);
        sda = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic fake_kick();
        @(negedge clk) scl = 1'b0;
        repeat (4) @(negedge clk);
        sda = 1'b0;
        repeat (4) @(negedge clk);
        sda = 1'b1;
        repeat (4) @(negedge clk);
        scl = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk("R1 reset", sys_rst, 1'b1);
        chk("R1 abort", bus_abort, 1'b1);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 abort low supply", bus_abort, 1'b1);
    endtask

    task automatic t_powerup();
        pwr_ok = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 abort off", bus_abort, 1'b0);
        ticks(HOLD - 1);
        chk("R2 still held", sys_rst, 1'b1);
        ticks(1);
        chk("R2 released", sys_rst, 1'b0);
    endtask

    task automatic t_expire_and_rehold();
        ticks(PF - 1);
        chk("R5 fast not yet", sys_rst, 1'b0);
        ticks(1);
        chk("R5 fast expiry", sys_rst, 1'b1);
        chk("R4 no abort wd hold", bus_abort, 1'b0);
        ticks(HOLD - 1);
        chk("R9 hold still", sys_rst, 1'b1);
        ticks(1);
        chk("R9 hold ends", sys_rst, 1'b0);
    endtask

    task automatic t_restart();
        ticks(PF - 1);
        kick();
        ticks(PF - 1);
        chk("R7 reloaded", sys_rst, 1'b0);
        ticks(1);
        chk("R7 expiry after reload", sys_rst, 1'b1);
    endtask

    task automatic t_kick_in_hold();
        ticks(3);
        kick();
        ticks(HOLD - 4);
        chk("R8 hold not cut", sys_rst, 1'b1);
        ticks(1);
        chk("R8 hold length kept", sys_rst, 1'b0);
    endtask

    task automatic t_sel_deferred();
        sel = 2'b01;
        ticks(PF - 1);
        chk("R10 old period", sys_rst, 1'b0);
        ticks(1);
        chk("R10 old period expiry", sys_rst, 1'b1);
        ticks(HOLD);
        ticks(PM - 1);
        chk("R5 mid not yet", sys_rst, 1'b0);
        ticks(1);
        chk("R5 mid expiry", sys_rst, 1'b1);
        sel = 2'b00;
        ticks(HOLD);
        ticks(PS - 1);
        chk("R5 slow not yet", sys_rst, 1'b0);
        ticks(1);
        chk("R5 slow expiry", sys_rst, 1'b1);
        ticks(HOLD);
    endtask

    task automatic t_fake_start();
        sel = 2'b10;
        kick();
        ticks(6);
        fake_kick();
        ticks(PF - 7);
        chk("R7 no reload scl low", sys_rst, 1'b0);
        ticks(1);
        chk("R7 expiry kept", sys_rst, 1'b1);
        ticks(HOLD);
    endtask

    task automatic t_disabled();
        sel = 2'b11;
        kick();
        ticks(3 * PS);
        chk("R6 watchdog off", sys_rst, 1'b0);
    endtask

    task automatic t_supply_drop();
        @(negedge clk) pwr_ok = 1'b0;
        #1;
        chk("R3 immediate reset", sys_rst, 1'b1);
        chk("R4 abort on drop", bus_abort, 1'b1);
        repeat (3) @(negedge clk);
        pwr_ok = 1'b1;
        repeat (2) @(negedge clk);
        ticks(5);
        @(negedge clk) pwr_ok = 1'b0;
        #1;
        chk("R3 reset on glitch", sys_rst, 1'b1);
        repeat (3) @(negedge clk);
        pwr_ok = 1'b1;
        repeat (2) @(negedge clk);
        ticks(HOLD - 1);
        chk("R3 hold restarted", sys_rst, 1'b1);
        ticks(1);
        chk("R3 release after full hold", sys_rst, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_expire_and_rehold();
        t_restart();
        t_kick_in_hold();
        t_sel_deferred();
        t_fake_start();
        t_disabled();
        t_supply_drop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d expected <100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule